// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer with Result Realignment

This block walks a 16-bit channel mask and runs one conversion per set bit on an external serial converter. Mask bits 0 to 7 are single-ended inputs; bits 8 to 15 are differential pairs. Each conversion is started by a 16-clock SPI frame whose first byte is the instruction. After every start the block waits for a rising edge on the converter's end-of-conversion line and then moves on to the next channel.

The converter shifts out the result of the previous conversion while it receives the next instruction. The block therefore discards the word that arrives with the first frame of a scan and tags every later word with the channel converted one step earlier. After the last channel it sends one extra status-read frame to fetch the final result. Results are offered one at a time on a valid/ready output that holds a single entry. If that entry has not been taken, the sequencer waits before it opens the next frame.

Top module: `adcseq_scan_seq`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is low, and `busy`, `res_valid` and `scan_err` are low. `spi_cs_n` is high whenever `busy` is low.
- R2: Set mask bits are converted in ascending index order, one frame per bit. For index c below 8 the instruction byte is 0x80 | (m(c) << 4). For index c of 8 or more the byte is m(c-8) << 4, with bit 7 clear. The table m maps 0..7 to 0,4,1,5,2,6,3,7. The second byte is 0x00.
- R3: Each frame holds `spi_cs_n` low for exactly 16 `spi_sclk` pulses. `spi_sclk` idles low. `spi_mosi` sends MSB first and changes on falling edges. `spi_miso` is sampled on rising edges.
- R4: The word received in a scan's first frame is dropped. The word received in frame k (k ≥ 1) is delivered with `res_chan` equal to the mask index converted in frame k-1.
- R5: After the last channel's end of conversion, one frame with instruction byte 0x0C is sent. The word it returns is delivered tagged with the last channel.
- R6: `res_value` is bits 15..3 of the received big-endian word, read as a 13-bit two's-complement number. Bits 2..0 are discarded.
- R7: After each conversion frame, no further frame starts until a rising edge is seen on `eoc`.
- R8: If no rising edge on `eoc` arrives within `EOC_TIMEOUT` clocks, the scan is aborted. `scan_err` goes high and stays high until reset, `busy` falls and `spi_cs_n` stays high. A later scan still runs normally.
- R9: A start with an all-zero mask causes no `busy`, no frame and no result.
- R10: While `res_valid` is high and `res_ready` is low, `res_value` and `res_chan` hold steady and no new frame begins. No result is lost.
- R11: For a frame that carries a result, `res_valid` rises exactly one clock after `spi_cs_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a scan when idle |
| chan_mask | input | 16 | Channels to scan, sampled on start |
| busy | output | 1 | Scan in progress |
| scan_err | output | 1 | Sticky end-of-conversion timeout flag |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Instruction data to the converter |
| spi_miso | input | 1 | Result data from the converter |
| eoc | input | 1 | End-of-conversion from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_value | output | RES_BITS | Signed conversion result |
| res_chan | output | 4 | Mask index the result belongs to |

## Verification
With `SCLK_HALF` = 1, `spi_cs_n` falls on the clock after the start (or after the launch), and a frame lasts 32 clocks. `res_valid` rises one clock after `spi_cs_n` rises. An `eoc` edge takes effect SYNC_STAGES+1 clocks after it is driven. The bench drives every input a short delay after a rising edge and samples every output on falling edges. On each result-bearing frame it reads `res_valid` on the first falling edge after `spi_cs_n` rises and expects low, then on the second and expects high. Whole-scan checks are made only after `busy` has fallen and a few settling cycles have passed. Expected instruction bytes, channel order and signed values are computed from the mask and from the converter model's own sequence counter.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   localparam int MASK_W   = 16;
   localparam int CH_W     = 4;
   localparam int CMD_BITS = 8;
   localparam logic [CMD_BITS-1:0] STATUS_CMD = 8'h0C;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LAUNCH,
      ST_XFER,
      ST_EOC
   } seq_state_e;

   // interleaved multiplexer code: 0..7 -> 0,4,1,5,2,6,3,7
   function automatic logic [2:0] mux_code(input logic [2:0] c);
      return {c[0], c[2:1]};
   endfunction

   // index 0..7 single-ended (bit 7 set), 8..15 pair led by index-8
   function automatic logic [CMD_BITS-1:0] conv_cmd(input logic [CH_W-1:0] idx);
      return {~idx[3], mux_code(idx[2:0]), 4'b0000};
   endfunction

   function automatic logic [CH_W-1:0] lowest_set(input logic [MASK_W-1:0] m);
      logic [CH_W-1:0] r;
      r = '0;
      for (int i = MASK_W - 1; i >= 0; i--) begin
         if (m[i]) r = i[CH_W-1:0];
      end
      return r;
   endfunction

endpackage

// File: rtl/adcseq_spi.sv
module adcseq_spi #(
   parameter int FRAME_BITS = 16,
   parameter int SCLK_HALF  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [FRAME_BITS-1:0] tx_word,
   output logic                  done,
   output logic [FRAME_BITS-1:0] rx_word,
   output logic                  sclk,
   output logic                  cs_n,
   output logic                  mosi,
   input  logic                  miso
);

   localparam int DIVW = $clog2(SCLK_HALF + 1);
   localparam int BITW = $clog2(FRAME_BITS);

   logic [DIVW-1:0]       div;
   logic [BITW-1:0]       nbit;
   logic [FRAME_BITS-1:0] tx_sh;
   logic [FRAME_BITS-1:0] rx_sh;
   logic                  act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act   <= 1'b0;
         cs_n  <= 1'b1;
         sclk  <= 1'b0;
         done  <= 1'b0;
         div   <= '0;
         nbit  <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
      end else begin
         done <= 1'b0;
         if (!act) begin
            if (go) begin
               act   <= 1'b1;
               cs_n  <= 1'b0;
               tx_sh <= tx_word;
               div   <= '0;
               nbit  <= '0;
            end
         end else if (div == DIVW'(SCLK_HALF - 1)) begin
            div <= '0;
            if (!sclk) begin
               sclk  <= 1'b1;
               rx_sh <= {rx_sh[FRAME_BITS-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (nbit == BITW'(FRAME_BITS - 1)) begin
                  act  <= 1'b0;
                  cs_n <= 1'b1;
                  done <= 1'b1;
               end else begin
                  nbit  <= nbit + 1'b1;
                  tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
               end
            end
         end else begin
            div <= div + 1'b1;
         end
      end
   end

   assign mosi    = act ? tx_sh[FRAME_BITS-1] : 1'b0;
   assign rx_word = rx_sh;

   // R3: serial clock only toggles inside a frame
   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R3: a frame ends only after the last bit position
   p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $past(nbit) == BITW'(FRAME_BITS - 1));

endmodule

// File: rtl/adcseq_eoc.sv
module adcseq_eoc #(
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT     = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_in,
   input  logic arm,
   output logic hit,
   output logic expire
);

   localparam int CNTW = $clog2(TIMEOUT + 1);

   logic            eoc_s;
   logic            eoc_d;
   logic [CNTW-1:0] cnt;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign eoc_s = eoc_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= (chain << 1) | SYNC_STAGES'(eoc_in);
      end
      assign eoc_s = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoc_d <= 1'b0;
         cnt   <= '0;
      end else begin
         eoc_d <= eoc_s;
         if (!arm) cnt <= '0;
         else if (cnt != CNTW'(TIMEOUT - 1)) cnt <= cnt + 1'b1;
      end
   end

   assign hit    = arm & eoc_s & ~eoc_d;
   assign expire = arm & ~hit & (cnt == CNTW'(TIMEOUT - 1));

   // R8: the wait counter never passes the timeout limit
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNTW'(TIMEOUT - 1));

endmodule

// File: rtl/adcseq_scan_seq.sv
module adcseq_scan_seq
   import adcseq_pkg::*;
#(
   parameter int SCLK_HALF   = 2,
   parameter int EOC_TIMEOUT = 10_000_000,
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_BITS  = 16,
   parameter int RES_BITS    = 13
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [15:0]                chan_mask,
   output logic                       busy,
   output logic                       scan_err,
   output logic                       spi_sclk,
   output logic                       spi_cs_n,
   output logic                       spi_mosi,
   input  logic                       spi_miso,
   input  logic                       eoc,
   output logic                       res_valid,
   input  logic                       res_ready,
   output logic signed [RES_BITS-1:0] res_value,
   output logic [3:0]                 res_chan
);

   localparam int PAD_BITS = FRAME_BITS - CMD_BITS;
   localparam int LOW_BITS = FRAME_BITS - RES_BITS;

   if (SCLK_HALF < 1) begin : g_bad_half
      $error("SCLK_HALF must be at least 1");
   end
   if (EOC_TIMEOUT < 2) begin : g_bad_tmo
      $error("EOC_TIMEOUT must be at least 2");
   end
   if (PAD_BITS < 1 || LOW_BITS < 1) begin : g_bad_frame
      $error("FRAME_BITS must exceed both the command and result widths");
   end

   seq_state_e            state;
   logic [MASK_W-1:0]     pend;
   logic [CH_W-1:0]       cur_ch;
   logic [CH_W-1:0]       prev_ch;
   logic                  have_prev;
   logic                  final_x;
   logic                  go;
   logic                  xfer_done;
   logic                  eoc_hit;
   logic                  eoc_expire;
   logic [CH_W-1:0]       nxt_ch;
   logic [CMD_BITS-1:0]   cmd;
   logic [FRAME_BITS-1:0] tx_word;
   logic [FRAME_BITS-1:0] rx_word;
   logic                  unused_rx;

   assign nxt_ch    = lowest_set(pend);
   assign cmd       = (pend != '0) ? conv_cmd(nxt_ch) : STATUS_CMD;
   assign tx_word   = {cmd, {PAD_BITS{1'b0}}};
   assign go        = (state == ST_LAUNCH) && !res_valid;
   assign busy      = (state != ST_IDLE);
   assign unused_rx = ^rx_word[LOW_BITS-1:0];

   adcseq_spi #(
      .FRAME_BITS (FRAME_BITS),
      .SCLK_HALF  (SCLK_HALF)
   ) u_spi (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .tx_word (tx_word),
      .done    (xfer_done),
      .rx_word (rx_word),
      .sclk    (spi_sclk),
      .cs_n    (spi_cs_n),
      .mosi    (spi_mosi),
      .miso    (spi_miso)
   );

   adcseq_eoc #(
      .SYNC_STAGES (SYNC_STAGES),
      .TIMEOUT     (EOC_TIMEOUT)
   ) u_eoc (
      .clk    (clk),
      .rst_n  (rst_n),
      .eoc_in (eoc),
      .arm    (state == ST_EOC),
      .hit    (eoc_hit),
      .expire (eoc_expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend      <= '0;
         cur_ch    <= '0;
         prev_ch   <= '0;
         have_prev <= 1'b0;
         final_x   <= 1'b0;
         scan_err  <= 1'b0;
         res_valid <= 1'b0;
         res_value <= '0;
         res_chan  <= '0;
      end else begin
         if (res_valid && res_ready) res_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start && chan_mask != '0) begin
                  pend      <= chan_mask;
                  have_prev <= 1'b0;
                  state     <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: begin
               if (go) begin
                  prev_ch <= cur_ch;
                  if (pend != '0) begin
                     cur_ch  <= nxt_ch;
                     pend    <= pend & ~(MASK_W'(1) << nxt_ch);
                     final_x <= 1'b0;
                  end else begin
                     final_x <= 1'b1;
                  end
                  state <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (xfer_done) begin
                  if (have_prev) begin
                     res_valid <= 1'b1;
                     res_value <= rx_word[FRAME_BITS-1 -: RES_BITS];
                     res_chan  <= prev_ch;
                  end
                  have_prev <= 1'b1;
                  state     <= final_x ? ST_IDLE : ST_EOC;
               end
            end
            ST_EOC: begin
               if (eoc_hit) begin
                  state <= ST_LAUNCH;
               end else if (eoc_expire) begin
                  scan_err <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: a waiting result holds still
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_value) && $stable(res_chan)));

   // R10: no frame opens while a result is still waiting
   p_no_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> !$past(res_valid));

   // R8: the timeout flag is sticky
   p_sticky_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_err |=> scan_err);

   // R1: chip select stays released while idle
   p_idle_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n);

   // R7: a new frame after the first needs an eoc edge in between
   p_eoc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EOC && !eoc_hit) |=> spi_cs_n);

endmodule

// File: tb/adcseq_scan_seq_bench.sv
`timescale 1ns/1ps
module adcseq_scan_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SCLK_HALF  = 1;
   localparam int TMO        = 300;
   localparam int EOC_DLY    = 12;
   localparam int LOG_N      = 4096;

   logic               clk;
   logic               rst_n;
   logic               start;
   logic [15:0]        chan_mask;
   logic               busy;
   logic               scan_err;
   logic               spi_sclk;
   logic               spi_cs_n;
   logic               spi_mosi;
   logic               spi_miso;
   logic               eoc;
   logic               res_valid;
   logic               res_ready;
   logic signed [12:0] res_value;
   logic [3:0]         res_chan;

   adcseq_scan_seq #(
      .SCLK_HALF   (SCLK_HALF),
      .EOC_TIMEOUT (TMO),
      .SYNC_STAGES (2),
      .FRAME_BITS  (16),
      .RES_BITS    (13)
   ) u_adcseq_scan_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .chan_mask (chan_mask),
      .busy      (busy),
      .scan_err  (scan_err),
      .spi_sclk  (spi_sclk),
      .spi_cs_n  (spi_cs_n),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso),
      .eoc       (eoc),
      .res_valid (res_valid),
      .res_ready (res_ready),
      .res_value (res_value),
      .res_chan  (res_chan)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_checks = 0;
   int n_err    = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   int mux_tbl[8] = '{0, 4, 1, 5, 2, 6, 3, 7};

   function automatic logic [7:0] exp_cmd(input int ch);
      if (ch < 8) return 8'(8'h80 | (mux_tbl[ch] << 4));
      return 8'(mux_tbl[ch - 8] << 4);
   endfunction

   function automatic logic [12:0] gen_val(input int k);
      return 13'((k * 1237 + 4001) % 8192);
   endfunction

   // converter model
   logic [15:0] resp_word;
   logic [15:0] cap;
   int          nrise;
   int          conv_seq;
   int          n_xfer;
   bit          eoc_en;
   logic [7:0]  instr_log [LOG_N];

   assign spi_miso = (nrise < 16) ? resp_word[4'(15 - nrise)] : 1'b0;

   always @(negedge spi_cs_n or posedge spi_sclk) begin
      if (!spi_sclk) begin
         nrise = 0;
         cap   = '0;
      end else begin
         cap   = {cap[14:0], spi_mosi};
         nrise = nrise + 1;
      end
   end

   always @(posedge spi_cs_n) begin
      if (n_xfer < LOG_N) instr_log[n_xfer] = cap[15:8];
      n_xfer = n_xfer + 1;
      if (cap[15:8] != 8'h0C) begin
         resp_word = {gen_val(conv_seq), 3'b110};
         conv_seq  = conv_seq + 1;
         if (eoc_en) begin
            repeat (EOC_DLY) @(negedge clk);
            eoc = 1'b1;
            repeat (3) @(negedge clk);
            eoc = 1'b0;
         end
      end
   end

   // result collector
   logic [12:0] got_val [LOG_N];
   logic [3:0]  got_ch  [LOG_N];
   int          n_out;

   always @(negedge clk) begin
      if (res_valid && res_ready && n_out < LOG_N) begin
         got_val[n_out] = res_value;
         got_ch[n_out]  = res_chan;
         n_out = n_out + 1;
      end
   end

   // R11: result latency after each result-bearing frame
   int lat_total;
   int lat_base;
   bit lat_en;

   always @(posedge spi_cs_n) begin
      int   k;
      logic v0;
      logic v1;
      k = lat_total;
      lat_total = lat_total + 1;
      @(negedge clk) v0 = res_valid;
      @(negedge clk) v1 = res_valid;
      if (lat_en && k > lat_base) chk(!v0 && v1, "R11 valid one clock after cs_n rise", {30'd0, v0, v1}, 1);
   end

   task automatic pulse_start(input logic [15:0] m);
      @(posedge clk);
      #2;
      chan_mask = m;
      start     = 1'b1;
      @(posedge clk);
      #2;
      start = 1'b0;
   endtask

   task automatic wait_idle(input int lim);
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic check_scan(input logic [15:0] m, input int bx, input int bo, input int bs);
      int exp_ch [16];
      int n;
      n = 0;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            exp_ch[n] = i;
            n++;
         end
      end
      if (n == 0) begin
         chk(n_xfer == bx, "R9 no frame for empty mask", n_xfer - bx, 0);
         chk(n_out == bo, "R9 no result for empty mask", n_out - bo, 0);
      end else begin
         chk(n_xfer - bx == n + 1, "R2 frame count", n_xfer - bx, n + 1);
         for (int j = 0; j < n; j++)
            chk(instr_log[bx + j] == exp_cmd(exp_ch[j]), "R2 instruction byte",
                int'(instr_log[bx + j]), int'(exp_cmd(exp_ch[j])));
         chk(instr_log[bx + n] == 8'h0C, "R5 trailing status read", int'(instr_log[bx + n]), 12);
         chk(n_out - bo == n, "R4 result count", n_out - bo, n);
         for (int j = 0; j < n; j++) begin
            chk(int'(got_ch[bo + j]) == exp_ch[j], "R4 channel tag", int'(got_ch[bo + j]), exp_ch[j]);
            chk(got_val[bo + j] == gen_val(bs + j), "R6 signed value",
                int'(got_val[bo + j]), int'(gen_val(bs + j)));
         end
      end
   endtask

   task automatic run_scan(input logic [15:0] m);
      int bx;
      int bo;
      int bs;
      bx = n_xfer;
      bo = n_out;
      bs = conv_seq;
      lat_base = lat_total;
      lat_en   = 1'b1;
      pulse_start(m);
      if (m == 16'h0000) chk(!busy, "R9 busy stays low", int'(busy), 0);
      wait_idle(20000);
      repeat (4) @(negedge clk);
      lat_en = 1'b0;
      check_scan(m, bx, bo, bs);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         chk(!spi_sclk || !spi_cs_n, "R3 sclk idle low outside frame", int'(spi_sclk), 0);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      rst_n     = 1'b0;
      start     = 1'b0;
      chan_mask = '0;
      res_ready = 1'b1;
      eoc       = 1'b0;
      eoc_en    = 1'b1;
      resp_word = 16'hFFFF;
      conv_seq  = 0;
      n_xfer    = 0;
      n_out     = 0;
      lat_total = 0;
      lat_base  = 0;
      lat_en    = 1'b0;
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(spi_cs_n, "R1 cs_n high after reset", int'(spi_cs_n), 1);
      chk(!spi_sclk, "R1 sclk low after reset", int'(spi_sclk), 0);
      chk(!busy, "R1 busy low after reset", int'(busy), 0);
      chk(!res_valid, "R1 no result after reset", int'(res_valid), 0);
      chk(!scan_err, "R1 no error after reset", int'(scan_err), 0);

      run_scan(16'h0001);
      run_scan(16'h8000);
      run_scan(16'h0000);
      run_scan(16'hFFFF);
      run_scan(16'h00FF);
      run_scan(16'hFF00);
      run_scan(16'hA5A5);
      run_scan(16'h5A5A);
      for (int b = 0; b < 16; b++) run_scan(16'h0001 << b);
      lf = 16'hACE1;
      for (int s = 0; s < 8; s++) begin
         for (int t = 0; t < 5; t++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         run_scan(lf);
      end
      chk(!scan_err, "R8 no error on healthy scans", int'(scan_err), 0);

      // R10: backpressure
      begin
         int bx;
         int bo;
         int bs;
         int xh;
         logic [12:0] hv;
         logic [3:0]  hc;
         bx = n_xfer;
         bo = n_out;
         bs = conv_seq;
         res_ready = 1'b0;
         pulse_start(16'h0C03);
         for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (res_valid) break;
         end
         hv = res_value;
         hc = res_chan;
         xh = n_xfer;
         repeat (150) @(negedge clk);
         chk(res_valid, "R10 result held", int'(res_valid), 1);
         chk(res_value == hv, "R10 value stable", int'(res_value), int'(hv));
         chk(res_chan == hc, "R10 tag stable", int'(res_chan), int'(hc));
         chk(n_xfer == xh, "R10 no frame while held", n_xfer, xh);
         chk(spi_cs_n, "R10 cs_n high while held", int'(spi_cs_n), 1);
         @(posedge clk);
         #2 res_ready = 1'b1;
         wait_idle(20000);
         repeat (4) @(negedge clk);
         check_scan(16'h0C03, bx, bo, bs);
      end

      // R8: timeout
      begin
         int bx;
         int bo;
         bx = n_xfer;
         bo = n_out;
         eoc_en = 1'b0;
         pulse_start(16'h0006);
         wait_idle(5000);
         @(negedge clk);
         chk(scan_err, "R8 error raised on timeout", int'(scan_err), 1);
         chk(!busy, "R8 busy low after abort", int'(busy), 0);
         chk(spi_cs_n, "R8 cs_n released after abort", int'(spi_cs_n), 1);
         chk(n_xfer - bx == 1, "R7 no frame without eoc edge", n_xfer - bx, 1);
         chk(n_out == bo, "R8 no result from aborted scan", n_out - bo, 0);
         eoc_en = 1'b1;
      end
      run_scan(16'h0081);
      chk(scan_err, "R8 error stays set", int'(scan_err), 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule